// File: doc/BRIEF.md
# Multi-Dataset Stimulus Sequencer

This block replays a fixed series of stimulus datasets into a downstream sample-processing stage. Each dataset has two parts. The first is a parameter set: a frame length, a sub-frame count and a detection threshold. The second is a run of input samples. The sample words come from a constant ROM per dataset, built at elaboration from a generator function. The parameter values and the run length of each dataset are module parameters, so no files are read.

After reset the sequencer is idle and no samples leave the block. The parameter outputs already show the first dataset. A one-cycle start pulse launches playback. For each dataset in turn, the sequencer spends one load cycle that strobes parameter-valid, then streams that dataset's samples back to back. After the final dataset it stays in a terminal done state. Consumers latch the parameters on the parameter-valid strobe and take one sample per sample-valid cycle.

Top module: `stim_sequencer`

## Requirements
- R1: After reset, sample-valid, parameter-valid and done are low and the index is 0. The parameter outputs show dataset 0's frame length, sub-frame count and threshold. This holds for as long as no start pulse arrives.
- R2: A start input that is high at a clock edge while idle makes parameter-valid high in the next cycle, with index 0.
- R3: Each load cycle lasts exactly one cycle and asserts parameter-valid with the new dataset's parameter values. Sample-valid is high in the cycle that follows.
- R4: Datasets play strictly in order 0, 1, 2. The index output (0 for the first dataset up to NUM_DS-1 for the last) names the dataset being loaded or streamed.
- R5: Dataset k issues exactly DS_LEN[k] consecutive sample-valid cycles, one sample per cycle. Sample j has the value ((k*4096) + j*(k+3) + 7) mod 2^DATA_W.
- R6: Sample-valid is high only while samples stream and is never high together with parameter-valid.
- R7: After the last sample of the last dataset, done goes high in the next cycle and stays high. No valid of either kind appears after that.
- R8: A start pulse during a load, while streaming or when done has no effect. Playback order and sample values are unchanged, and done stays set.
- R9: The index and parameter outputs hold steady for the whole of a dataset's sample run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start pulse |
| smp_data_o | output | DATA_W | Sample word, zero when not valid |
| smp_vld_o | output | 1 | Sample word valid |
| prm_n_o | output | PRM_W | Frame length of selected dataset |
| prm_nframe_o | output | PRM_W | Sub-frame count of selected dataset |
| prm_thresh_o | output | PRM_W | Detection threshold of selected dataset |
| prm_vld_o | output | 1 | Parameter-set strobe (load cycle) |
| ds_idx_o | output | IDX_W | Index of the current dataset |
| done_o | output | 1 | All datasets played |

## Verification
The assertions check several properties on every cycle:
- the two valid flags never overlap;
- a load is always followed directly by streaming;
- the index moves up by exactly one per load;
- the index stays steady inside a run;
- the last sample of the last dataset leads straight into a done state that never ends;
- a late start never reopens dataset 0.

Only the bench's scenarios can show that each run has the right length and the right sample values, that the parameter values match each dataset, and that the block stays silent while idle. They also show that start pulses injected during a load, in mid-stream and after completion change none of the output sequence.

// File: rtl/stim_seq_pkg.sv
package stim_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_STREAM = 2'd2,
    ST_DONE   = 2'd3
  } seq_state_e;

  // Generator for the stimulus words held in each dataset ROM.
  function automatic int unsigned sample_word(int unsigned ds, int unsigned pos);
    return (ds << 12) + pos * (ds + 3) + 7;
  endfunction

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import stim_seq_pkg::*;
#(
  parameter int          NUM_DS  = 3,
  parameter int          ADDR_W  = 4,
  parameter int          IDX_W   = 2,
  parameter int unsigned DS_LEN [NUM_DS] = '{5, 3, 7}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output seq_state_e        state_o,
  output logic [IDX_W-1:0]  ds_idx_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              start_take_o,
  output logic              last_smp_o,
  output logic              last_ds_o
);

  seq_state_e        state_q;
  logic [IDX_W-1:0]  ds_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] last_addr;

  assign last_addr    = ADDR_W'(DS_LEN[ds_q] - 1);
  assign start_take_o = (state_q == ST_IDLE) && start_i;
  assign last_smp_o   = (state_q == ST_STREAM) && (addr_q == last_addr);
  assign last_ds_o    = (ds_q == IDX_W'(NUM_DS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ds_q    <= '0;
      addr_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) state_q <= ST_LOAD;
        end
        ST_LOAD: begin
          state_q <= ST_STREAM;
          addr_q  <= '0;
        end
        ST_STREAM: begin
          if (last_smp_o) begin
            addr_q <= '0;
            if (last_ds_o) begin
              state_q <= ST_DONE;
            end else begin
              state_q <= ST_LOAD;
              ds_q    <= ds_q + IDX_W'(1);
            end
          end else begin
            addr_q <= addr_q + ADDR_W'(1);
          end
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end

  assign state_o  = state_q;
  assign ds_idx_o = ds_q;
  assign addr_o   = addr_q;

endmodule

// File: rtl/seq_sample_rom.sv
module seq_sample_rom
  import stim_seq_pkg::*;
#(
  parameter int          NUM_DS  = 3,
  parameter int          DATA_W  = 16,
  parameter int          MAX_LEN = 16,
  parameter int          ADDR_W  = 4,
  parameter int          IDX_W   = 2,
  parameter int unsigned DS_LEN [NUM_DS] = '{5, 3, 7}
) (
  input  logic [IDX_W-1:0]  ds_idx_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] word_o
);

  logic [DATA_W-1:0] bank_word [NUM_DS];

  for (genvar g = 0; g < NUM_DS; g++) begin : g_bank
    logic [DATA_W-1:0] rom [MAX_LEN];
    for (genvar i = 0; i < MAX_LEN; i++) begin : g_word
      if (i < DS_LEN[g]) begin : g_used
        assign rom[i] = DATA_W'(sample_word(unsigned'(g), unsigned'(i)));
      end else begin : g_pad
        assign rom[i] = '0;
      end
    end
    assign bank_word[g] = rom[addr_i];
  end

  assign word_o = bank_word[ds_idx_i];

endmodule

// File: rtl/seq_param_bank.sv
module seq_param_bank #(
  parameter int          NUM_DS = 3,
  parameter int          PRM_W  = 16,
  parameter int          IDX_W  = 2,
  parameter int unsigned DS_N      [NUM_DS] = '{64, 128, 32},
  parameter int unsigned DS_NFRAME [NUM_DS] = '{4, 8, 2},
  parameter int unsigned DS_THRESH [NUM_DS] = '{100, 250, 40}
) (
  input  logic [IDX_W-1:0] ds_idx_i,
  output logic [PRM_W-1:0] n_o,
  output logic [PRM_W-1:0] nframe_o,
  output logic [PRM_W-1:0] thresh_o
);

  assign n_o      = PRM_W'(DS_N[ds_idx_i]);
  assign nframe_o = PRM_W'(DS_NFRAME[ds_idx_i]);
  assign thresh_o = PRM_W'(DS_THRESH[ds_idx_i]);

endmodule

// File: rtl/stim_sequencer.sv
module stim_sequencer
  import stim_seq_pkg::*;
#(
  parameter int          NUM_DS  = 3,
  parameter int          DATA_W  = 16,
  parameter int          PRM_W   = 16,
  parameter int          MAX_LEN = 16,
  parameter int unsigned DS_LEN    [NUM_DS] = '{5, 3, 7},
  parameter int unsigned DS_N      [NUM_DS] = '{64, 128, 32},
  parameter int unsigned DS_NFRAME [NUM_DS] = '{4, 8, 2},
  parameter int unsigned DS_THRESH [NUM_DS] = '{100, 250, 40},
  localparam int         IDX_W   = (NUM_DS > 1) ? $clog2(NUM_DS) : 1,
  localparam int         ADDR_W  = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic [DATA_W-1:0] smp_data_o,
  output logic              smp_vld_o,
  output logic [PRM_W-1:0]  prm_n_o,
  output logic [PRM_W-1:0]  prm_nframe_o,
  output logic [PRM_W-1:0]  prm_thresh_o,
  output logic              prm_vld_o,
  output logic [IDX_W-1:0]  ds_idx_o,
  output logic              done_o
);

  // Named internal events, observed by the bound checker.
  seq_state_e        state;
  logic [ADDR_W-1:0] addr;
  logic              start_take;
  logic              last_smp;
  logic              last_ds;
  logic [DATA_W-1:0] rom_word;

  seq_ctrl #(
    .NUM_DS (NUM_DS),
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .DS_LEN (DS_LEN)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .state_o      (state),
    .ds_idx_o     (ds_idx_o),
    .addr_o       (addr),
    .start_take_o (start_take),
    .last_smp_o   (last_smp),
    .last_ds_o    (last_ds)
  );

  seq_sample_rom #(
    .NUM_DS  (NUM_DS),
    .DATA_W  (DATA_W),
    .MAX_LEN (MAX_LEN),
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W),
    .DS_LEN  (DS_LEN)
  ) u_rom (
    .ds_idx_i (ds_idx_o),
    .addr_i   (addr),
    .word_o   (rom_word)
  );

  seq_param_bank #(
    .NUM_DS    (NUM_DS),
    .PRM_W     (PRM_W),
    .IDX_W     (IDX_W),
    .DS_N      (DS_N),
    .DS_NFRAME (DS_NFRAME),
    .DS_THRESH (DS_THRESH)
  ) u_prm (
    .ds_idx_i (ds_idx_o),
    .n_o      (prm_n_o),
    .nframe_o (prm_nframe_o),
    .thresh_o (prm_thresh_o)
  );

  assign smp_vld_o  = (state == ST_STREAM);
  assign prm_vld_o  = (state == ST_LOAD);
  assign done_o     = (state == ST_DONE);
  assign smp_data_o = smp_vld_o ? rom_word : '0;

endmodule

// File: rtl/stim_sequencer_chk.sv
module stim_sequencer_chk #(
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             smp_vld_o,
  input logic             prm_vld_o,
  input logic             done_o,
  input logic [IDX_W-1:0] ds_idx_o,
  input logic             start_take,
  input logic             last_smp,
  input logic             last_ds
);

  assert_excl_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_vld_o && prm_vld_o));

  assert_load_then_stream_R3: assert property (@(posedge clk) disable iff (!rst_n)
    prm_vld_o |=> (smp_vld_o && !prm_vld_o));

  assert_start_opens_ds0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_take |=> (prm_vld_o && ds_idx_o == '0));

  assert_index_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (prm_vld_o && !$past(start_take)) |-> (ds_idx_o == IDX_W'($past(ds_idx_o) + 1'b1)));

  assert_index_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld_o && $past(smp_vld_o)) |-> $stable(ds_idx_o));

  assert_final_to_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (last_smp && last_ds) |=> done_o);

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (done_o && !smp_vld_o && !prm_vld_o));

  assert_late_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && (smp_vld_o || prm_vld_o || done_o)) |=> !(prm_vld_o && ds_idx_o == '0));

endmodule

bind stim_sequencer stim_sequencer_chk #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .smp_vld_o  (smp_vld_o),
  .prm_vld_o  (prm_vld_o),
  .done_o     (done_o),
  .ds_idx_o   (ds_idx_o),
  .start_take (start_take),
  .last_smp   (last_smp),
  .last_ds    (last_ds)
);

// File: tb/tb_stim_sequencer.sv
module tb_stim_sequencer;

  localparam int DATA_W = 16;
  localparam int PRM_W  = 16;
  localparam int NDS    = 3;
  localparam int LEN    [NDS] = '{5, 3, 7};
  localparam int FRM    [NDS] = '{64, 128, 32};
  localparam int SUB    [NDS] = '{4, 8, 2};
  localparam int THR    [NDS] = '{100, 250, 40};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [DATA_W-1:0] smp_data_o;
  logic              smp_vld_o;
  logic [PRM_W-1:0]  prm_n_o, prm_nframe_o, prm_thresh_o;
  logic              prm_vld_o;
  logic [1:0]        ds_idx_o;
  logic              done_o;

  int n_chk = 0;
  int n_err = 0;
  int n_smp = 0;

  typedef struct {
    bit is_prm;
    int ds;
    int val;
  } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  stim_sequencer dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .smp_data_o(smp_data_o), .smp_vld_o(smp_vld_o),
    .prm_n_o(prm_n_o), .prm_nframe_o(prm_nframe_o), .prm_thresh_o(prm_thresh_o),
    .prm_vld_o(prm_vld_o), .ds_idx_o(ds_idx_o), .done_o(done_o)
  );

  function automatic int ref_word(int k, int j);
    return (k * 4096 + k * j + 3 * j + 7) % 65536;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive_dataset(int k);
    exp_t e;
    e.is_prm = 1'b1; e.ds = k; e.val = 0;
    exp_q.push_back(e);
    for (int j = 0; j < LEN[k]; j++) begin
      e.is_prm = 1'b0; e.ds = k; e.val = ref_word(k, j);
      exp_q.push_back(e);
    end
  endtask

  // Monitor: pops one expected item per valid cycle.
  always @(negedge clk) begin
    if (rst_n && (prm_vld_o || smp_vld_o)) begin
      check(!(prm_vld_o && smp_vld_o), "R6", "both valids high", 1, 0);
      if (exp_q.size() == 0) begin
        check(1'b0, "R6", "unexpected valid output, queue empty", int'(smp_vld_o), 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(int'(ds_idx_o) == e.ds, "R4", "dataset index", int'(ds_idx_o), e.ds);
        if (e.is_prm) begin
          check(prm_vld_o == 1'b1, "R3", "parameter strobe expected", int'(prm_vld_o), 1);
          check(int'(prm_n_o) == FRM[e.ds], "R3", "frame length", int'(prm_n_o), FRM[e.ds]);
          check(int'(prm_nframe_o) == SUB[e.ds], "R3", "sub-frame count", int'(prm_nframe_o), SUB[e.ds]);
          check(int'(prm_thresh_o) == THR[e.ds], "R3", "threshold", int'(prm_thresh_o), THR[e.ds]);
        end else begin
          n_smp++;
          check(smp_vld_o == 1'b1, "R5", "sample expected", int'(smp_vld_o), 1);
          check(int'(smp_data_o) == e.val, "R5", "sample word", int'(smp_data_o), e.val);
          check(int'(prm_n_o) == FRM[e.ds] && int'(prm_thresh_o) == THR[e.ds],
                "R9", "parameters steady in run", int'(prm_n_o), FRM[e.ds]);
        end
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "WATCHDOG", "run did not complete", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R1: idle state after reset
    check(smp_vld_o == 1'b0, "R1", "sample valid after reset", int'(smp_vld_o), 0);
    check(prm_vld_o == 1'b0, "R1", "param valid after reset", int'(prm_vld_o), 0);
    check(done_o == 1'b0, "R1", "done after reset", int'(done_o), 0);
    check(ds_idx_o == 2'd0, "R1", "index after reset", int'(ds_idx_o), 0);
    check(int'(prm_n_o) == FRM[0] && int'(prm_nframe_o) == SUB[0] && int'(prm_thresh_o) == THR[0],
          "R1", "dataset 0 parameters shown in idle", int'(prm_n_o), FRM[0]);
    repeat (10) @(negedge clk);
    check(smp_vld_o == 1'b0 && prm_vld_o == 1'b0, "R1", "silent without start",
          int'(smp_vld_o), 0);

    for (int k = 0; k < NDS; k++) drive_dataset(k);

    // R2: start pulse
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(prm_vld_o == 1'b1 && ds_idx_o == 2'd0, "R2", "load follows start",
          int'(prm_vld_o), 1);
    @(negedge clk);
    check(smp_vld_o == 1'b1 && prm_vld_o == 1'b0, "R3", "stream follows load",
          int'(smp_vld_o), 1);
    // R8: start pulse mid-stream
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;

    // R8: start pulse during the load of dataset 1
    for (int t = 0; t < 100 && !(prm_vld_o && ds_idx_o == 2'd1); t++) @(negedge clk);
    check(prm_vld_o == 1'b1 && ds_idx_o == 2'd1, "R4", "second load reached",
          int'(ds_idx_o), 1);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;

    for (int t = 0; t < 200 && !done_o; t++) @(negedge clk);
    check(done_o == 1'b1, "R7", "done after last dataset", int'(done_o), 1);
    check(exp_q.size() == 0, "R5", "all expected items consumed", exp_q.size(), 0);
    check(n_smp == LEN[0] + LEN[1] + LEN[2], "R5", "total sample count", n_smp,
          LEN[0] + LEN[1] + LEN[2]);

    // R8: start pulse after done
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (12) @(negedge clk);
    check(done_o == 1'b1, "R8", "done held after late start", int'(done_o), 1);
    check(smp_vld_o == 1'b0 && prm_vld_o == 1'b0, "R7", "no output after done",
          int'(smp_vld_o), 0);
    check(n_smp == LEN[0] + LEN[1] + LEN[2], "R8", "no replay after late start", n_smp,
          LEN[0] + LEN[1] + LEN[2]);
    finish_run();
  end

endmodule